// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block produces the two supervisory outputs of a supply monitor: an active-low system reset and an active-low watchdog alarm. It takes an already-digitised "supply is above its trip level" flag, a manual-reset button input, a shared chip-select line whose falling edges double as watchdog kicks, a flag that reports battery-backup operation, and a two-bit period selector held in a status register. All asynchronous inputs are synchronised into the block clock before use.

Time is kept in milliseconds. A prescaler divides the block clock by `CLKS_PER_MS` to make a one-cycle millisecond tick. Every delay in the block is a count of those ticks, so a shortened scale can be used in simulation. The reset output is held for a fixed stretch after the supply recovers or after the button is released. The manual button is debounced on the same tick. The watchdog counts ticks toward the selected period and raises its alarm for a fixed stretch when the host fails to kick it.

Top module: `sup_reset_wdog`

## Requirements
- R1: While the synchronised supply flag is low, `rst_n_o` is 0 within four clock cycles.
- R2: After `rst` (power-up) `rst_n_o` is 0, and it goes to 1 only after the supply flag has stayed high for `HOLD_MS` ms ticks (default 150).
- R3: Each high-to-low transition on `cs_wdi_i` restarts the watchdog count. Kicks spaced closer than the selected period keep `wdo_n_o` at 1.
- R4: `wd_period_i` selects the timeout: 2'b00 = `LONG_MS` (800), 2'b01 = `MID_MS` (400), 2'b10 = `SHORT_MS` (150), 2'b11 = watchdog off. When the code is off, `wdo_n_o` stays 1.
- R5: When no kick arrives within the selected period, `wdo_n_o` goes to 0 at the end of that period.
- R6: After a timeout, `wdo_n_o` stays 0 for `HOLD_MS` ms and then returns to 1, and the count starts again. A kick during this stretch returns `wdo_n_o` to 1 at once.
- R7: A level on `mr_n_i` that differs from the accepted level for fewer than `DEB_MS` ms ticks (default 10) has no effect on `rst_n_o`. After reset the accepted level is "released" (1).
- R8: While the debounced button is pressed (0), `rst_n_o` is 0. After release, `rst_n_o` stays 0 for the debounce time plus `HOLD_MS` ms.
- R9: While `batt_mode_i` is 1, the watchdog count is frozen. It resumes from the frozen value when the flag returns to 0.
- R10: A change of `wd_period_i` restarts the watchdog count from zero.
- R11: While `rst_n_o` is 0 the watchdog count is held at zero and `wdo_n_o` is 1. A new period is timed in full from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the logic (power-up) |
| supply_ok_i | input | 1 | Supply above trip level, asynchronous |
| mr_n_i | input | 1 | Manual reset button, active low, asynchronous |
| cs_wdi_i | input | 1 | Chip select line, falling edge kicks the watchdog |
| batt_mode_i | input | 1 | Battery-backup operation, freezes the watchdog |
| wd_period_i | input | 2 | Watchdog period selector |
| rst_n_o | output | 1 | System reset, active low, registered |
| wdo_n_o | output | 1 | Watchdog alarm, active low, registered |

## Verification
The watchdog is tried with each period code from a fresh kick. The time of the alarm is bracketed on both sides, which tells the three periods apart and shows that the off code never fires. Further runs apply a train of kicks, a silent run through a full timeout and its hold stretch, a kick during the hold, a period change in mid-count, and a battery-mode interval. These separate restart, release, early clear and freeze from one another. Reset is tried with a power-up, a brown-out during a pending watchdog count, a button glitch shorter than the debounce time and a long button press. These show the hold stretch, the ignored glitch, and the watchdog count being cleared while reset is asserted.

// File: rtl/sup_pkg.sv
package sup_pkg;

  // Watchdog period selector encoding
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;

  // Bit positions inside the synchronised input vector
  localparam int unsigned IN_SUP  = 0;
  localparam int unsigned IN_MR   = 1;
  localparam int unsigned IN_CS   = 2;
  localparam int unsigned IN_BATT = 3;
  localparam int unsigned IN_W    = 4;

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/sup_ms_tick.sv
module sup_ms_tick #(
  parameter int unsigned CLKS_PER_MS = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);

  localparam int unsigned PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      tick_o <= 1'b0;
    end else if (pre_q == LAST) begin
      pre_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

endmodule

// File: rtl/sup_debounce.sv
module sup_debounce #(
  parameter int unsigned DEB_MS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic lvl_i,
  output logic lvl_o
);

  localparam int unsigned DW = $clog2(DEB_MS + 1);
  localparam logic [DW-1:0] LAST = DW'(DEB_MS - 1);

  logic [DW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_o <= 1'b1;
    end else if (lvl_i == lvl_o) begin
      run_q <= '0;
    end else if (tick_i) begin
      if (run_q == LAST) begin
        run_q <= '0;
        lvl_o <= lvl_i;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sup_rst_hold.sv
module sup_rst_hold #(
  parameter int unsigned HOLD_MS = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic fault_i,
  output logic active_o
);

  localparam int unsigned HW = $clog2(HOLD_MS + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_MS - 1);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      active_o <= 1'b1;
    end else if (fault_i) begin
      hold_q   <= '0;
      active_o <= 1'b1;
    end else if (active_o && tick_i) begin
      if (hold_q == LAST) begin
        hold_q   <= '0;
        active_o <= 1'b0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int unsigned HOLD_MS  = 150,
  parameter int unsigned LONG_MS  = 800,
  parameter int unsigned MID_MS   = 400,
  parameter int unsigned SHORT_MS = 150
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       sys_rst_i,
  input  logic       cs_i,
  input  logic       freeze_i,
  input  logic [1:0] sel_i,
  output logic       alarm_o
);

  localparam int unsigned MAXP = (LONG_MS > MID_MS) ?
                                 ((LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS) :
                                 ((MID_MS > SHORT_MS) ? MID_MS : SHORT_MS);
  localparam int unsigned MAXC = (MAXP > HOLD_MS) ? MAXP : HOLD_MS;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  function automatic logic [CW-1:0] period_last(input wd_sel_e s);
    case (s)
      SEL_LONG:  period_last = CW'(LONG_MS - 1);
      SEL_MID:   period_last = CW'(MID_MS - 1);
      SEL_SHORT: period_last = CW'(SHORT_MS - 1);
      default:   period_last = '0;
    endcase
  endfunction

  wd_sel_e       sel;
  wd_sel_e       sel_prev_q;
  logic          cs_prev_q;
  logic          kick;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] end_val;

  assign sel     = wd_sel_e'(sel_i);
  assign kick    = cs_prev_q & ~cs_i;
  assign end_val = alarm_o ? CW'(HOLD_MS - 1) : period_last(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      alarm_o    <= 1'b0;
      cs_prev_q  <= 1'b1;
      sel_prev_q <= SEL_LONG;
    end else begin
      cs_prev_q  <= cs_i;
      sel_prev_q <= sel;
      if (sys_rst_i || (sel == SEL_OFF) || kick) begin
        cnt_q   <= '0;
        alarm_o <= 1'b0;
      end else if (sel != sel_prev_q) begin
        cnt_q <= '0;
      end else if (!freeze_i && tick_i) begin
        if (cnt_q == end_val) begin
          cnt_q   <= '0;
          alarm_o <= ~alarm_o;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog
  import sup_pkg::*;
#(
  parameter int unsigned CLKS_PER_MS = 1000,
  parameter int unsigned HOLD_MS     = 150,
  parameter int unsigned DEB_MS      = 10,
  parameter int unsigned LONG_MS     = 800,
  parameter int unsigned MID_MS      = 400,
  parameter int unsigned SHORT_MS    = 150,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       mr_n_i,
  input  logic       cs_wdi_i,
  input  logic       batt_mode_i,
  input  logic [1:0] wd_period_i,
  output logic       rst_n_o,
  output logic       wdo_n_o
);

  localparam logic [IN_W-1:0] SYNC_RST = (IN_W'(1) << IN_MR) | (IN_W'(1) << IN_CS);

  logic [IN_W-1:0] raw_in;
  logic [IN_W-1:0] syn_in;
  logic            tick;
  logic            mr_deb;
  logic            rst_active;
  logic            alarm;

  assign raw_in[IN_SUP]  = supply_ok_i;
  assign raw_in[IN_MR]   = mr_n_i;
  assign raw_in[IN_CS]   = cs_wdi_i;
  assign raw_in[IN_BATT] = batt_mode_i;

  sup_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn_in)
  );

  sup_ms_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  sup_debounce #(.DEB_MS(DEB_MS)) u_deb (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .lvl_i  (syn_in[IN_MR]),
    .lvl_o  (mr_deb)
  );

  sup_rst_hold #(.HOLD_MS(HOLD_MS)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .fault_i  (~syn_in[IN_SUP] | ~mr_deb),
    .active_o (rst_active)
  );

  sup_wdog #(
    .HOLD_MS  (HOLD_MS),
    .LONG_MS  (LONG_MS),
    .MID_MS   (MID_MS),
    .SHORT_MS (SHORT_MS)
  ) u_wdog (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .sys_rst_i (rst_active),
    .cs_i      (syn_in[IN_CS]),
    .freeze_i  (syn_in[IN_BATT]),
    .sel_i     (wd_period_i),
    .alarm_o   (alarm)
  );

  assign rst_n_o = ~rst_active;
  assign wdo_n_o = ~alarm;

endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok_i,
  input logic [1:0] wd_period_i,
  input logic       rst_n_o,
  input logic       wdo_n_o
);

  // R1: a supply flag low for four cycles forces reset
  p_supply_low_r1: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok_i && !$past(supply_ok_i) && !$past(supply_ok_i, 2) &&
     !$past(supply_ok_i, 3) && !$past(supply_ok_i, 4)) |-> !rst_n_o);

  // R2: reset is released only after the supply flag has been high
  p_release_after_good_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> ($past(supply_ok_i, 3) && $past(supply_ok_i, 4)));

  // R4: the off code keeps the alarm quiet
  p_code_off_r4: assert property (@(posedge clk) disable iff (rst)
    (wd_period_i == 2'b11 && $past(wd_period_i) == 2'b11) |-> wdo_n_o);

  // R5: an alarm starts only while the watchdog may run
  p_wdo_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(wdo_n_o) |-> ($past(rst_n_o) && $past(wd_period_i) != 2'b11));

  // R11: reset quiets the alarm on the next cycle
  p_reset_quiets_wdo_r11: assert property (@(posedge clk) disable iff (rst)
    !rst_n_o |=> wdo_n_o);

endmodule

bind sup_reset_wdog sup_reset_wdog_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_ok_i (supply_ok_i),
  .wd_period_i (wd_period_i),
  .rst_n_o     (rst_n_o),
  .wdo_n_o     (wdo_n_o)
);

// File: tb/sup_reset_wdog_bench.sv
module sup_reset_wdog_bench;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CPM        = 4;
  localparam int unsigned WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0;
  logic       mr_n = 1'b1;
  logic       cs = 1'b1;
  logic       batt = 1'b0;
  logic [1:0] wd_sel = 2'b10;
  logic       rst_n;
  logic       wdo_n;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sup_reset_wdog #(.CLKS_PER_MS(CPM)) u_sup_reset_wdog (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok),
    .mr_n_i      (mr_n),
    .cs_wdi_i    (cs),
    .batt_mode_i (batt),
    .wd_period_i (wd_sel),
    .rst_n_o     (rst_n),
    .wdo_n_o     (wdo_n)
  );

  task automatic wait_ms(input int n);
    repeat (n * CPM) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic kick();
    cs = 1'b0;
    repeat (4) @(negedge clk);
    cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check("R2", "reset level after rst", rst_n, 1'b0);
    check("R11", "alarm idle after rst", wdo_n, 1'b1);
    rst = 1'b0;
  endtask

  task automatic t_powerup();
    supply_ok = 1'b1;
    wait_ms(145);
    check("R2", "reset held before hold end", rst_n, 1'b0);
    wait_ms(10);
    check("R2", "reset released after hold", rst_n, 1'b1);
  endtask

  task automatic t_period(input logic [1:0] code, input int ms);
    wd_sel = code;
    repeat (3) @(negedge clk);
    kick();
    wait_ms(ms - 5);
    check("R4", "alarm idle before period end", wdo_n, 1'b1);
    wait_ms(10);
    check("R5", "alarm after missed kick", wdo_n, 1'b0);
    kick();
    check("R6", "kick clears alarm in hold", wdo_n, 1'b1);
  endtask

  task automatic t_hold();
    wd_sel = 2'b10;
    kick();
    wait_ms(155);
    check("R5", "alarm after short period", wdo_n, 1'b0);
    wait_ms(140);
    check("R6", "alarm still held", wdo_n, 1'b0);
    wait_ms(10);
    check("R6", "alarm released after hold", wdo_n, 1'b1);
    wait_ms(140);
    check("R6", "restarted count not yet expired", wdo_n, 1'b1);
    wait_ms(10);
    check("R6", "second alarm after restart", wdo_n, 1'b0);
    kick();
  endtask

  task automatic t_kicks();
    wd_sel = 2'b10;
    kick();
    for (int i = 0; i < 6; i++) begin
      wait_ms(100);
      check("R3", "kick train keeps alarm idle", wdo_n, 1'b1);
      kick();
    end
  endtask

  task automatic t_off();
    wd_sel = 2'b11;
    wait_ms(900);
    check("R4", "off code never alarms", wdo_n, 1'b1);
  endtask

  task automatic t_change();
    wd_sel = 2'b01;
    repeat (3) @(negedge clk);
    kick();
    wait_ms(300);
    check("R10", "mid period still running", wdo_n, 1'b1);
    wd_sel = 2'b10;
    wait_ms(140);
    check("R10", "count restarted on change", wdo_n, 1'b1);
    wait_ms(20);
    check("R10", "alarm one short period after change", wdo_n, 1'b0);
    kick();
  endtask

  task automatic t_batt();
    wd_sel = 2'b10;
    kick();
    batt = 1'b1;
    wait_ms(300);
    check("R9", "frozen count in battery mode", wdo_n, 1'b1);
    batt = 1'b0;
    wait_ms(140);
    check("R9", "count resumed from frozen value", wdo_n, 1'b1);
    wait_ms(20);
    check("R9", "alarm after resumed period", wdo_n, 1'b0);
    kick();
  endtask

  task automatic t_brownout();
    wd_sel = 2'b10;
    kick();
    supply_ok = 1'b0;
    wait_ms(2);
    check("R1", "reset on supply loss", rst_n, 1'b0);
    wait_ms(300);
    check("R11", "alarm idle during reset", wdo_n, 1'b1);
    supply_ok = 1'b1;
    wait_ms(145);
    check("R2", "reset held after recovery", rst_n, 1'b0);
    wait_ms(10);
    check("R2", "reset released after recovery", rst_n, 1'b1);
    wait_ms(140);
    check("R11", "full period timed from release", wdo_n, 1'b1);
    wait_ms(20);
    check("R11", "alarm one period after release", wdo_n, 1'b0);
    kick();
  endtask

  task automatic t_manual();
    wd_sel = 2'b11;
    mr_n = 1'b0;
    wait_ms(5);
    check("R7", "short glitch ignored during", rst_n, 1'b1);
    mr_n = 1'b1;
    wait_ms(20);
    check("R7", "short glitch ignored after", rst_n, 1'b1);
    mr_n = 1'b0;
    wait_ms(20);
    check("R8", "reset while button held", rst_n, 1'b0);
    mr_n = 1'b1;
    wait_ms(150);
    check("R8", "reset held after release", rst_n, 1'b0);
    wait_ms(20);
    check("R8", "reset released after stretch", rst_n, 1'b1);
  endtask

  initial begin : main
    repeat (2) @(negedge clk);
    t_reset_state();
    t_powerup();
    t_period(2'b10, 150);
    t_period(2'b01, 400);
    t_period(2'b00, 800);
    t_hold();
    t_kicks();
    t_off();
    t_change();
    t_batt();
    t_brownout();
    t_manual();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule